// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after the translation cache has missed. A walk request brings the virtual address, a per-process master table base, the process tag and an access kind (read or write). The walker slices the address into a 10-bit master index, a 10-bit secondary index and a 12-bit page offset. It reads one master entry and then, if that entry is valid, one secondary entry. Both reads go through a simple read port that has a request handshake and allows only one read in flight. Each table is one 4 KB page of 4-byte entries.

Every accepted request gives exactly one single-cycle result. The result is either a fill, which carries the frame number, the physical address and the low flag field of the leaf entry, or a fault. A fault carries a not-valid or a protection-denied flag, the level at which the walk stopped, and the faulting virtual address and process tag. Only one walk is active at a time, and `req_ready` holds new requests off until the result has been given.

Entry layout used at both levels: bit 0 valid, bit 1 referenced, bit 2 modified, bit 3 read permission, bit 4 write permission, bits 31:12 the frame number (in a leaf entry) or the page-aligned base of a secondary table (in a master entry).

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: The first read of a walk is at `req_root + 4 * vaddr[31:22]`.
- R3: After a valid master entry, the second read is at `{master[31:12], vaddr[21:12], 2'b00}`.
- R4: A valid secondary entry that permits the access gives a fill with both fault flags at 0, `res_pfn = leaf[31:12]`, `res_paddr = {leaf[31:12], vaddr[11:0]}`, `res_pte_bits = leaf[11:0]` and `res_level = 1`.
- R5: A master entry with bit 0 clear ends the walk with no second read. The result has `res_fault_nv = 1`, `res_level = 0`, and the request's virtual address and process tag.
- R6: A secondary entry with bit 0 clear gives `res_fault_nv = 1` and `res_level = 1`, with the address and tag reported.
- R7: A write to a valid leaf with bit 4 clear gives `res_fault_prot = 1` and `res_fault_nv = 0`. A read ignores bit 4, and the protection bits of a master entry have no effect on the walk.
- R8: From the cycle after a request is accepted until the cycle after its result, `req_ready` is 0. No read is requested while `req_ready` is 1.
- R9: Each accepted request gives exactly one result, `res_valid` high for a single cycle, and results come in request order.
- R10: A memory read request that is not accepted stays asserted with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | input | 1 | walk request present |
| req_ready | output | 1 | walker idle, request taken this cycle |
| req_vaddr | input | 32 | virtual address to translate |
| req_root | input | 32 | master table base of the process |
| req_pid | input | 8 | process tag, echoed in the result |
| req_write | input | 1 | 1 for a write access |
| mem_req_valid | output | 1 | table read request |
| mem_req_ready | input | 1 | memory takes the read |
| mem_req_addr | output | 32 | byte address of the entry |
| mem_rsp_valid | input | 1 | read data present |
| mem_rsp_data | input | 32 | entry read |
| res_valid | output | 1 | one-cycle result pulse |
| res_pfn | output | 20 | frame number of the leaf |
| res_paddr | output | 32 | translated physical address |
| res_pte_bits | output | 12 | low flag field of the final entry |
| res_fault_nv | output | 1 | walk hit an entry not marked valid |
| res_fault_prot | output | 1 | write denied by the leaf |
| res_level | output | 1 | 0 walk stopped at master, 1 at secondary |
| res_vaddr | output | 32 | virtual address of the walk |
| res_pid | output | 8 | process tag of the walk |

## Verification
The assertions assume that memory gives exactly one response for each accepted read, no earlier than the cycle after the handshake, and that it never sends a response when no read is pending. They also assume that `req_root` keeps the entry index inside its page. The bench memory model schedules a single response one to three cycles after each handshake and lowers `mem_req_ready` at pseudo-random times. The driver holds a new request high while a walk is still active, so the hold-off is exercised in every run.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_SREQ,
    ST_SWAIT,
    ST_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    PTE_NEXT,
    PTE_FILL,
    PTE_NOTVALID,
    PTE_NOWRITE
  } pte_verdict_t;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_WR_BIT    = 4;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned PA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_LG = 2
) (
  input  logic [PA_W-1:0]       root,
  input  logic [IDX_W-1:0]      mst_idx,
  input  logic [IDX_W-1:0]      sec_idx,
  input  logic [PA_W-OFF_W-1:0] tbl_frame,
  output logic [PA_W-1:0]       mst_addr,
  output logic [PA_W-1:0]       sec_addr
);
  localparam int unsigned PAD_W = PA_W - IDX_W - ENT_LG;

  // Master entry: per-process base plus scaled index.
  assign mst_addr = root + {{PAD_W{1'b0}}, mst_idx, {ENT_LG{1'b0}}};
  // Secondary entry: page-aligned table frame with scaled index in the low page bits.
  assign sec_addr = {tbl_frame, sec_idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walk_pkg::*;
(
  input  logic         ent_valid,
  input  logic         ent_wr_ok,
  input  logic         leaf,
  input  logic         wr_access,
  output pte_verdict_t verdict
);
  always_comb begin
    if (!ent_valid)                  verdict = PTE_NOTVALID;
    else if (!leaf)                  verdict = PTE_NEXT;
    else if (wr_access && !ent_wr_ok) verdict = PTE_NOWRITE;
    else                             verdict = PTE_FILL;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PID_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_W-1:0]               req_vaddr,
  input  logic [PA_W-1:0]               req_root,
  input  logic [PID_W-1:0]              req_pid,
  input  logic                          req_write,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [PTE_W-1:0]              mem_rsp_data,
  output logic                          res_valid,
  output logic [PA_W-(VA_W-2*IDX_W)-1:0] res_pfn,
  output logic [PA_W-1:0]               res_paddr,
  output logic [VA_W-2*IDX_W-1:0]       res_pte_bits,
  output logic                          res_fault_nv,
  output logic                          res_fault_prot,
  output logic                          res_level,
  output logic [VA_W-1:0]               res_vaddr,
  output logic [PID_W-1:0]              res_pid
);
  localparam int unsigned OFF_W   = VA_W - 2*IDX_W;
  localparam int unsigned FRAME_W = PA_W - OFF_W;
  localparam int unsigned ENT_LG  = $clog2(PTE_W/8);

  walk_state_t            state;
  logic [PID_W-1:0]       pid_q;
  logic                   wr_q;
  logic [VA_W-1:0]        va_q;
  logic [PA_W-1:0]        addr_q;
  logic [PA_W-1:0]        mst_addr, sec_addr;
  pte_verdict_t           verdict;
  logic [FRAME_W-1:0]     ent_frame;

  assign ent_frame = mem_rsp_data[OFF_W +: FRAME_W];

  pt_addr_gen #(
    .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_LG(ENT_LG)
  ) u_addr (
    .root      (req_root),
    .mst_idx   (req_vaddr[VA_W-1 -: IDX_W]),
    .sec_idx   (va_q[OFF_W +: IDX_W]),
    .tbl_frame (ent_frame),
    .mst_addr  (mst_addr),
    .sec_addr  (sec_addr)
  );

  pt_pte_decode u_dec (
    .ent_valid (mem_rsp_data[PTE_VALID_BIT]),
    .ent_wr_ok (mem_rsp_data[PTE_WR_BIT]),
    .leaf      (state == ST_SWAIT),
    .wr_access (wr_q),
    .verdict   (verdict)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_MREQ) || (state == ST_SREQ);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (state == ST_DONE);
  assign res_vaddr     = va_q;
  assign res_pid       = pid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pid_q          <= '0;
      wr_q           <= 1'b0;
      va_q           <= '0;
      addr_q         <= '0;
      res_pfn        <= '0;
      res_paddr      <= '0;
      res_pte_bits   <= '0;
      res_fault_nv   <= 1'b0;
      res_fault_prot <= 1'b0;
      res_level      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            pid_q  <= req_pid;
            wr_q   <= req_write;
            addr_q <= mst_addr;
            state  <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_SREQ: if (mem_req_ready) state <= ST_SWAIT;
        ST_MWAIT, ST_SWAIT: begin
          if (mem_rsp_valid) begin
            if (verdict == PTE_NEXT) begin
              addr_q <= sec_addr;
              state  <= ST_SREQ;
            end else begin
              res_pfn        <= ent_frame;
              res_paddr      <= {ent_frame, va_q[OFF_W-1:0]};
              res_pte_bits   <= mem_rsp_data[OFF_W-1:0];
              res_fault_nv   <= (verdict == PTE_NOTVALID);
              res_fault_prot <= (verdict == PTE_NOWRITE);
              res_level      <= (state == ST_SWAIT);
              state          <= ST_DONE;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  // R8
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R7
  fault_kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_fault_nv && res_fault_prot));
  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault_nv && !res_fault_prot |->
      res_paddr[OFF_W-1:0] == res_vaddr[OFF_W-1:0]);
  // R5
  master_stop_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_level |-> res_fault_nv);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_root = '0;
  logic [7:0]  req_pid = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [19:0] res_pfn;
  logic [31:0] res_paddr;
  logic [11:0] res_pte_bits;
  logic        res_fault_nv, res_fault_prot, res_level;
  logic [31:0] res_vaddr;
  logic [7:0]  res_pid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_root(req_root), .req_pid(req_pid), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_pfn(res_pfn),
    .res_paddr(res_paddr), .res_pte_bits(res_pte_bits),
    .res_fault_nv(res_fault_nv), .res_fault_prot(res_fault_prot),
    .res_level(res_level), .res_vaddr(res_vaddr), .res_pid(res_pid)
  );

  typedef struct {
    logic        nv, prot, lvl;
    logic [19:0] pfn;
    logic [31:0] paddr;
    logic [11:0] bits;
    logic [31:0] va;
    logic [7:0]  pid;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  string       tag_q[$];
  logic [31:0] mem [logic [31:0]];

  int checks = 0;
  int fails  = 0;
  int inflight = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: computes the expected outcome from the requirements, then issues.
  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      input logic [7:0] pid, input logic wr);
    exp_t e;
    logic [31:0] ma, sa, m, s;
    ma = root + {20'h0, va[31:22], 2'b00};          // R2
    m  = rd(ma);
    addr_q.push_back(ma); tag_q.push_back("R2");
    e.va = va; e.pid = pid; e.prot = 1'b0;
    e.pfn = '0; e.paddr = '0; e.bits = '0;
    if (!m[0]) begin                                  // R5
      e.nv = 1'b1; e.lvl = 1'b0;
    end else begin
      sa = {m[31:12], va[21:12], 2'b00};             // R3
      s  = rd(sa);
      addr_q.push_back(sa); tag_q.push_back("R3");
      e.lvl = 1'b1;
      e.nv  = !s[0];                                  // R6
      e.prot = s[0] && wr && !s[4];                   // R7
      e.pfn = s[31:12]; e.paddr = {s[31:12], va[11:0]}; e.bits = s[11:0]; // R4
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_root = root; req_pid = pid; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Memory model: random stalls, one response 1..3 cycles after each handshake.
  int          pend_cnt = 0;
  logic [31:0] pend_data = '0;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
      end
    end
    mem_req_ready = lfsr[0] | lfsr[3];
    if (!rst && mem_req_valid && mem_req_ready) begin
      checks++;
      if (addr_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R3 unexpected read addr=%h expected none", mem_req_addr);
      end else begin
        logic [31:0] ea;
        string t;
        ea = addr_q.pop_front(); t = tag_q.pop_front();
        if (mem_req_addr !== ea) begin
          fails++;
          $display("FAIL %s read addr actual=%h expected=%h", t, mem_req_addr, ea);
        end
      end
      pend_data = rd(mem_req_addr);
      pend_cnt  = 1 + int'(lfsr[5:4] % 2'd3);
    end
  end

  // Monitor: samples between the falling edge and the next rising edge.
  logic        prev_res = 1'b0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(posedge clk) begin
    #(CLK_PERIOD*3/4);
    if (!rst) begin
      checks++;                                       // R8
      if (req_ready !== (inflight == 0)) begin
        fails++;
        $display("FAIL R8 req_ready actual=%b expected=%b", req_ready, inflight == 0);
      end
      if (mem_req_valid && req_ready) begin
        fails++; checks++;
        $display("FAIL R8 read while ready actual=1 expected=0");
      end
      if (prev_hold) begin                            // R10
        checks++;
        if (!mem_req_valid || mem_req_addr !== prev_addr) begin
          fails++;
          $display("FAIL R10 hold actual=%b/%h expected=1/%h", mem_req_valid, mem_req_addr, prev_addr);
        end
      end
      if (res_valid) begin
        checks++;
        if (prev_res) begin                           // R9
          fails++;
          $display("FAIL R9 res_valid actual=1 expected=0 (second cycle)");
        end else if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 result actual=1 expected=none pending");
        end else begin
          exp_t e;
          string t;
          logic bad;
          e = exp_q.pop_front();
          t = e.nv ? (e.lvl ? "R6" : "R5") : (e.prot ? "R7" : "R4");
          bad = (res_fault_nv !== e.nv) || (res_fault_prot !== e.prot) ||
                (res_level !== e.lvl) || (res_vaddr !== e.va) || (res_pid !== e.pid);
          if (!e.nv && !e.prot)
            bad = bad || (res_pfn !== e.pfn) || (res_paddr !== e.paddr) || (res_pte_bits !== e.bits);
          if (bad) begin
            fails++;
            $display("FAIL %s result actual nv=%b pr=%b lv=%b va=%h pid=%h pfn=%h pa=%h bits=%h expected nv=%b pr=%b lv=%b va=%h pid=%h pfn=%h pa=%h bits=%h",
              t, res_fault_nv, res_fault_prot, res_level, res_vaddr, res_pid, res_pfn, res_paddr, res_pte_bits,
              e.nv, e.prot, e.lvl, e.va, e.pid, e.pfn, e.paddr, e.bits);
          end
        end
        inflight = inflight - 1;
      end
      if (req_valid && req_ready) inflight = inflight + 1;
      prev_res  = res_valid;
      prev_hold = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  logic [31:0] vas   [8];
  logic [31:0] roots [8];
  logic [7:0]  pids  [8];

  initial begin
    // Process 1 tables
    mem[32'h0001_0004] = 32'h0005_0001;   // master valid, protection bits clear
    mem[32'h0005_000C] = 32'h1234_5019;   // rd+wr
    mem[32'h0005_0010] = 32'h0ABC_D009;   // read only
    mem[32'h0005_0014] = 32'h0000_0000;   // not valid
    // Process 2 tables
    mem[32'h0002_0004] = 32'h0006_0003;
    mem[32'h0006_000C] = 32'hFFFF_F01F;
    mem[32'h0002_0FFC] = 32'h0007_0001;
    mem[32'h0007_0FFC] = 32'h0000_1007;   // valid, no permissions

    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    checks += 3;                                      // R1
    if (req_ready !== 1'b1) begin fails++; $display("FAIL R1 req_ready actual=%b expected=1", req_ready); end
    if (mem_req_valid !== 1'b0) begin fails++; $display("FAIL R1 mem_req_valid actual=%b expected=0", mem_req_valid); end
    if (res_valid !== 1'b0) begin fails++; $display("FAIL R1 res_valid actual=%b expected=0", res_valid); end
    rst = 1'b0;

    walk(32'h0040_3ABC, 32'h0001_0000, 8'h01, 1'b0);  // R4 fill
    walk(32'h0040_3ABC, 32'h0001_0000, 8'h01, 1'b1);  // R4/R7 write ok, master prot ignored
    walk(32'h0040_4123, 32'h0001_0000, 8'h01, 1'b1);  // R7 write denied
    walk(32'h0040_4123, 32'h0001_0000, 8'h01, 1'b0);  // R7 read ignores bit 4
    walk(32'h0040_5000, 32'h0001_0000, 8'h01, 1'b0);  // R6
    walk(32'h0080_0000, 32'h0001_0000, 8'h01, 1'b1);  // R5
    walk(32'h0040_3ABC, 32'h0002_0000, 8'h02, 1'b0);  // R4 other process
    walk(32'hFFFF_FFFF, 32'h0002_0000, 8'h02, 1'b0);  // R2/R3 top indices
    walk(32'hFFFF_FFFF, 32'h0002_0000, 8'h02, 1'b1);  // R7

    vas[0] = 32'h0040_3ABC; roots[0] = 32'h0001_0000; pids[0] = 8'h01;
    vas[1] = 32'h0040_4123; roots[1] = 32'h0001_0000; pids[1] = 8'h01;
    vas[2] = 32'h0040_5000; roots[2] = 32'h0001_0000; pids[2] = 8'h01;
    vas[3] = 32'h0080_0000; roots[3] = 32'h0001_0000; pids[3] = 8'h01;
    vas[4] = 32'h0040_3ABC; roots[4] = 32'h0002_0000; pids[4] = 8'h02;
    vas[5] = 32'hFFFF_FFFF; roots[5] = 32'h0002_0000; pids[5] = 8'h02;
    vas[6] = 32'h0040_3001; roots[6] = 32'h0002_0000; pids[6] = 8'h22;
    vas[7] = 32'hFFC0_0000; roots[7] = 32'h0001_0000; pids[7] = 8'h11;
    for (int i = 0; i < 60; i++) begin
      int k;
      k = (i * 7 + 3) % 8;
      walk(vas[k], roots[k], pids[k], i[1]);
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;                                         // R9
    if (inflight != 0 || addr_q.size() != 0) begin
      fails++;
      $display("FAIL R9 leftover actual=%0d/%0d expected=0/0", inflight, addr_q.size());
    end
    summary();
  end
endmodule